// File: doc/BRIEF.md
# Power Mode Clock Gating Controller

This block sets the low-power state of a small controller chip and drives the clock-gate enables that carry that state. The processor core sends a wait request or a stop request. Software-owned control bits set which requests are honoured and what each low-power mode switches off. A wake pulse brings the chip back to full operation, and reset does the same. The controller drives enables for the core clock, the memory clocks, the system clock, one clock per peripheral, the PLL and the oscillator. It also drives a run enable for the watchdog and a disable for the motor-PWM outputs.

Wait mode keeps the peripherals, the PLL and the oscillator running. Stop mode cuts every logic clock. A deep-stop bit, read when Stop is entered, also switches off the PLL and the oscillator. That gives the lowest power, but the restart takes longer. On wake, the clocks come back one group per cycle: oscillator, then PLL, then system and peripheral clocks, and last the core and memory. Every output comes from a register, so it can drive a glitch-free clock-gate cell directly.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After a synchronous reset, mode is 0 (run). The core, memory, system, PLL and oscillator enables are 1. All peripheral enables are 0, watchdog run is 1 and PWM disable is 0.
- R2: In run, a wait request with the wait-enable bit set moves to mode 1 (wait) at the next edge. Core, memory and system enables go to 0. PLL and oscillator stay 1, and the peripheral enables keep following their gate bits.
- R3: In run, a stop request with the stop-enable bit set moves to mode 2 (stop) at the next edge. Core, memory, system and all peripheral enables go to 0. If deep stop is not selected, PLL and oscillator stay 1.
- R4: If the deep-stop bit is 1 on the cycle Stop is entered, the PLL and oscillator enables also go to 0. The bit is captured at entry, so later changes to it have no effect until the chip wakes.
- R5: A request whose enable bit is clear leaves the chip in run. When wait and stop are both requested and both enabled, stop wins.
- R6: A wake pulse in wait, or in a stop that is not deep, gives one cycle of mode 3 (waking). In that cycle system, peripheral, PLL and oscillator enables are on and core and memory are off. Run follows on the next cycle.
- R7: A wake from deep stop gives three cycles of mode 3. The first has only the oscillator on, the second adds the PLL, and the third adds the system and peripheral clocks. Run follows, and the core clock is never on unless the system clock was already on.
- R8: Watchdog run is 0 while in stop, while in wait with the wait-watchdog-stop bit set, and on the cycle after the debug input is high. Otherwise it is 1.
- R9: PWM disable is 1 while in wait with the wait-PWM-off bit set, or on the cycle after debug is high with the debug-PWM-off bit set. Otherwise it is 0.
- R10: In run, wait and the last waking cycle, peripheral enable i equals gate bit i, sampled one edge earlier.
- R11: Wait and stop requests are ignored outside run. A wake pulse in run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wait_req | input | 1 | Core request to enter wait |
| stop_req | input | 1 | Core request to enter stop |
| wake | input | 1 | Wake pulse from the interrupt logic |
| debug_mode | input | 1 | Chip is under debugger control |
| cfg_wait_en | input | 1 | Honour wait requests |
| cfg_stop_en | input | 1 | Honour stop requests |
| cfg_stop_deep | input | 1 | Stop also switches off PLL and oscillator |
| cfg_wait_wdog_off | input | 1 | Halt the watchdog during wait |
| cfg_wait_pwm_off | input | 1 | Force PWM outputs off during wait |
| cfg_dbg_pwm_off | input | 1 | Force PWM outputs off during debug |
| periph_gate | input | N_PERIPH | Per-peripheral clock gate bits from software |
| mode | output | 2 | 0 run, 1 wait, 2 stop, 3 waking |
| core_clk_en | output | 1 | Core clock enable |
| mem_clk_en | output | 1 | Memory clock enable |
| sys_clk_en | output | 1 | System clock enable |
| per_clk_en | output | N_PERIPH | Peripheral clock enables |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |
| wdog_run | output | 1 | Watchdog run enable |
| pwm_disable | output | 1 | Force motor-PWM outputs off |

## Verification
The hardest case to reach is the capture of the deep-stop bit. The bit has to be set on exactly the cycle of the stop request and then cleared while the chip is still stopped. The wake that follows must then still run the full three-step restart. The vector table does this in consecutive rows, each row one clock edge. It also shows that a wait request arriving during stop does nothing. A later directed test resets the chip while it is in deep stop and checks that every enable comes back at once.

// File: rtl/pwr_pkg.sv
// Package: shared state encoding and clock-enable bundle for the power-mode
// controller. Assumes one clock domain for all controller state.
package pwr_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_WAIT   = 3'd1,
        ST_STOP   = 3'd2,
        ST_WK_OSC = 3'd3,
        ST_WK_PLL = 3'd4,
        ST_WK_CLK = 3'd5
    } pm_state_e;

    typedef struct packed {
        logic core;
        logic mem;
        logic sys;
        logic per;
        logic pll;
        logic osc;
    } clk_en_s;

    localparam logic [1:0] MODE_RUN  = 2'd0;
    localparam logic [1:0] MODE_WAIT = 2'd1;
    localparam logic [1:0] MODE_STOP = 2'd2;
    localparam logic [1:0] MODE_WAKE = 2'd3;

endpackage

// File: rtl/pwr_mode_fsm.sv
// Module: mode state machine. Accepts gated wait/stop requests in run only,
// leaves wait or stop on a wake pulse and steps through the restart states.
// Captures the deep-stop choice on stop entry. Exposes the next state so that
// the output registers can load the enables together with the state.
module pwr_mode_fsm
    import pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wait_req,
    input  logic      stop_req,
    input  logic      wake,
    input  logic      cfg_wait_en,
    input  logic      cfg_stop_en,
    input  logic      cfg_stop_deep,
    output pm_state_e state_q,
    output pm_state_e state_nxt,
    output logic      deep_nxt
);

    logic deep_q;
    logic take_stop;
    logic take_wait;

    // Qualify requests with their enable bits; stop has priority over wait.
    always_comb begin
        take_stop = stop_req && cfg_stop_en;
        take_wait = wait_req && cfg_wait_en && !take_stop;
    end

    // Next-state and deep-flag selection.
    always_comb begin
        state_nxt = state_q;
        deep_nxt  = deep_q;
        unique case (state_q)
            ST_RUN: begin
                if (take_stop) begin
                    state_nxt = ST_STOP;
                    deep_nxt  = cfg_stop_deep;
                end else if (take_wait) begin
                    state_nxt = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (wake) state_nxt = ST_WK_CLK;
            end
            ST_STOP: begin
                if (wake) state_nxt = deep_q ? ST_WK_OSC : ST_WK_CLK;
            end
            ST_WK_OSC: state_nxt = ST_WK_PLL;
            ST_WK_PLL: state_nxt = ST_WK_CLK;
            ST_WK_CLK: begin
                state_nxt = ST_RUN;
                deep_nxt  = 1'b0;
            end
            default: begin
                state_nxt = ST_RUN;
                deep_nxt  = 1'b0;
            end
        endcase
    end

    // State and deep-flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            deep_q  <= 1'b0;
        end else begin
            state_q <= state_nxt;
            deep_q  <= deep_nxt;
        end
    end

endmodule

// File: rtl/pwr_en_decode.sv
// Module: combinational decode of a controller state into clock-group enables,
// watchdog halt and PWM blanking. Pure logic; the caller registers the result.
module pwr_en_decode
    import pwr_pkg::*;
(
    input  pm_state_e state,
    input  logic      deep,
    input  logic      debug_mode,
    input  logic      cfg_wait_wdog_off,
    input  logic      cfg_wait_pwm_off,
    input  logic      cfg_dbg_pwm_off,
    output clk_en_s   en,
    output logic      wdog_halt,
    output logic      pwm_off,
    output logic [1:0] mode_code
);

    // Clock groups and mode code per state.
    always_comb begin
        en        = '0;
        mode_code = MODE_WAKE;
        unique case (state)
            ST_RUN: begin
                en        = '1;
                mode_code = MODE_RUN;
            end
            ST_WAIT: begin
                en.per    = 1'b1;
                en.pll    = 1'b1;
                en.osc    = 1'b1;
                mode_code = MODE_WAIT;
            end
            ST_STOP: begin
                en.pll    = !deep;
                en.osc    = !deep;
                mode_code = MODE_STOP;
            end
            ST_WK_OSC: en.osc = 1'b1;
            ST_WK_PLL: begin
                en.osc = 1'b1;
                en.pll = 1'b1;
            end
            ST_WK_CLK: begin
                en.osc = 1'b1;
                en.pll = 1'b1;
                en.sys = 1'b1;
                en.per = 1'b1;
            end
            default: begin
                en        = '1;
                mode_code = MODE_RUN;
            end
        endcase
    end

    // Watchdog halt and PWM blanking from mode, debug and option bits.
    always_comb begin
        wdog_halt = debug_mode || (state == ST_STOP)
                 || ((state == ST_WAIT) && cfg_wait_wdog_off);
        pwm_off   = (debug_mode && cfg_dbg_pwm_off)
                 || ((state == ST_WAIT) && cfg_wait_pwm_off);
    end

endmodule

// File: rtl/pwr_out_reg.sv
// Module: output register stage. Loads decoded enables on the same edge as the
// state so that every clock-gate enable leaves a flop. Peripheral enables are
// the group enable combined with each software gate bit.
module pwr_out_reg
    import pwr_pkg::*;
#(
    parameter int N_PERIPH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  clk_en_s             en,
    input  logic                wdog_halt,
    input  logic                pwm_off,
    input  logic [1:0]          mode_code,
    input  logic [N_PERIPH-1:0] periph_gate,
    output logic [1:0]          mode,
    output logic                core_clk_en,
    output logic                mem_clk_en,
    output logic                sys_clk_en,
    output logic [N_PERIPH-1:0] per_clk_en,
    output logic                pll_en,
    output logic                osc_en,
    output logic                wdog_run,
    output logic                pwm_disable
);

    // Shared group enables and control outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode        <= MODE_RUN;
            core_clk_en <= 1'b1;
            mem_clk_en  <= 1'b1;
            sys_clk_en  <= 1'b1;
            pll_en      <= 1'b1;
            osc_en      <= 1'b1;
            wdog_run    <= 1'b1;
            pwm_disable <= 1'b0;
        end else begin
            mode        <= mode_code;
            core_clk_en <= en.core;
            mem_clk_en  <= en.mem;
            sys_clk_en  <= en.sys;
            pll_en      <= en.pll;
            osc_en      <= en.osc;
            wdog_run    <= !wdog_halt;
            pwm_disable <= pwm_off;
        end
    end

    // One gated enable flop per peripheral.
    for (genvar i = 0; i < N_PERIPH; i++) begin : g_per
        always_ff @(posedge clk) begin
            if (!rst_n) per_clk_en[i] <= 1'b0;
            else        per_clk_en[i] <= en.per && periph_gate[i];
        end
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module: top of the power-mode clock gating controller. Joins the state
// machine, the enable decode and the output registers. Assumes single-cycle
// wake/request pulses are synchronous to clk.
module pwr_mode_ctrl
    import pwr_pkg::*;
#(
    parameter int N_PERIPH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wait_req,
    input  logic                stop_req,
    input  logic                wake,
    input  logic                debug_mode,
    input  logic                cfg_wait_en,
    input  logic                cfg_stop_en,
    input  logic                cfg_stop_deep,
    input  logic                cfg_wait_wdog_off,
    input  logic                cfg_wait_pwm_off,
    input  logic                cfg_dbg_pwm_off,
    input  logic [N_PERIPH-1:0] periph_gate,
    output logic [1:0]          mode,
    output logic                core_clk_en,
    output logic                mem_clk_en,
    output logic                sys_clk_en,
    output logic [N_PERIPH-1:0] per_clk_en,
    output logic                pll_en,
    output logic                osc_en,
    output logic                wdog_run,
    output logic                pwm_disable
);

    pm_state_e  state_q;
    pm_state_e  state_nxt;
    logic       deep_nxt;
    clk_en_s    en_nxt;
    logic       wdog_halt_nxt;
    logic       pwm_off_nxt;
    logic [1:0] mode_nxt;

    pwr_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wait_req      (wait_req),
        .stop_req      (stop_req),
        .wake          (wake),
        .cfg_wait_en   (cfg_wait_en),
        .cfg_stop_en   (cfg_stop_en),
        .cfg_stop_deep (cfg_stop_deep),
        .state_q       (state_q),
        .state_nxt     (state_nxt),
        .deep_nxt      (deep_nxt)
    );

    pwr_en_decode u_dec (
        .state             (state_nxt),
        .deep              (deep_nxt),
        .debug_mode        (debug_mode),
        .cfg_wait_wdog_off (cfg_wait_wdog_off),
        .cfg_wait_pwm_off  (cfg_wait_pwm_off),
        .cfg_dbg_pwm_off   (cfg_dbg_pwm_off),
        .en                (en_nxt),
        .wdog_halt         (wdog_halt_nxt),
        .pwm_off           (pwm_off_nxt),
        .mode_code         (mode_nxt)
    );

    pwr_out_reg #(.N_PERIPH(N_PERIPH)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en_nxt),
        .wdog_halt   (wdog_halt_nxt),
        .pwm_off     (pwm_off_nxt),
        .mode_code   (mode_nxt),
        .periph_gate (periph_gate),
        .mode        (mode),
        .core_clk_en (core_clk_en),
        .mem_clk_en  (mem_clk_en),
        .sys_clk_en  (sys_clk_en),
        .per_clk_en  (per_clk_en),
        .pll_en      (pll_en),
        .osc_en      (osc_en),
        .wdog_run    (wdog_run),
        .pwm_disable (pwm_disable)
    );

endmodule

// File: rtl/pwr_mode_chk.sv
// Module: property checker for the power-mode controller, attached by bind.
// Observes top-level ports only.
module pwr_mode_chk #(
    parameter int N_PERIPH = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wait_req,
    input logic                stop_req,
    input logic                wake,
    input logic                debug_mode,
    input logic                cfg_wait_en,
    input logic                cfg_stop_en,
    input logic [1:0]          mode,
    input logic                core_clk_en,
    input logic                sys_clk_en,
    input logic [N_PERIPH-1:0] per_clk_en,
    input logic                pll_en,
    input logic                osc_en,
    input logic                wdog_run
);

    assert_core_needs_sys_R7: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en |-> sys_clk_en);

    assert_pll_needs_osc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en |-> osc_en);

    assert_core_after_sys_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_clk_en) && $past(rst_n)) |-> $past(sys_clk_en));

    assert_stop_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> (!core_clk_en && !sys_clk_en && per_clk_en == '0));

    assert_debug_wdog_R8: assert property (@(posedge clk) disable iff (!rst_n)
        debug_mode |=> !wdog_run);

    assert_disabled_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && wait_req && !cfg_wait_en && !(stop_req && cfg_stop_en))
        |=> (mode == 2'd0));

    assert_wake_in_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && wake && !(stop_req && cfg_stop_en) && !(wait_req && cfg_wait_en))
        |=> (mode == 2'd0));

endmodule

bind pwr_mode_ctrl pwr_mode_chk #(.N_PERIPH(N_PERIPH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wait_req    (wait_req),
    .stop_req    (stop_req),
    .wake        (wake),
    .debug_mode  (debug_mode),
    .cfg_wait_en (cfg_wait_en),
    .cfg_stop_en (cfg_stop_en),
    .mode        (mode),
    .core_clk_en (core_clk_en),
    .sys_clk_en  (sys_clk_en),
    .per_clk_en  (per_clk_en),
    .pll_en      (pll_en),
    .osc_en      (osc_en),
    .wdog_run    (wdog_run)
);

// File: tb/sim_pwr_mode_ctrl.sv
// Bench: walks a vector table, one clock edge per row, then directed reset tests.
// Input row: {wait, stop, wake, debug, wait_en, stop_en, deep, wait_wdog_off,
//             wait_pwm_off, dbg_pwm_off, gate[3:0]}
// Expected row: {mode[1:0], core, mem, sys, pll, osc, per[3:0], wdog_run, pwm_disable}
module sim_pwr_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 4;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic [23:0] tag;
        logic [13:0] stim;
        logic [12:0] expv;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{"R10", 14'b0000_110110_1010, 13'b00_11111_1010_10},
        '{"R2 ", 14'b1000_110110_1010, 13'b01_00011_1010_01},
        '{"R6 ", 14'b0010_110110_1010, 13'b11_00111_1010_10},
        '{"R6 ", 14'b0000_110110_1010, 13'b00_11111_1010_10},
        '{"R3 ", 14'b0100_110110_1010, 13'b10_00011_0000_00},
        '{"R11", 14'b1000_110110_1010, 13'b10_00011_0000_00},
        '{"R6 ", 14'b0010_110110_1010, 13'b11_00111_1010_10},
        '{"R6 ", 14'b0000_110110_1010, 13'b00_11111_1010_10},
        '{"R4 ", 14'b0100_111110_1010, 13'b10_00000_0000_00},
        '{"R4 ", 14'b0000_110110_1010, 13'b10_00000_0000_00},
        '{"R7 ", 14'b0010_110110_1010, 13'b11_00001_0000_10},
        '{"R7 ", 14'b0000_110110_1010, 13'b11_00011_0000_10},
        '{"R7 ", 14'b0000_110110_1010, 13'b11_00111_1010_10},
        '{"R7 ", 14'b0000_110110_1010, 13'b00_11111_1010_10},
        '{"R5 ", 14'b1000_010110_1010, 13'b00_11111_1010_10},
        '{"R5 ", 14'b0100_100110_1010, 13'b00_11111_1010_10},
        '{"R5 ", 14'b1100_110110_1010, 13'b10_00011_0000_00},
        '{"R6 ", 14'b0010_110110_1010, 13'b11_00111_1010_10},
        '{"R6 ", 14'b0000_110110_1010, 13'b00_11111_1010_10},
        '{"R11", 14'b0010_110110_1010, 13'b00_11111_1010_10},
        '{"R9 ", 14'b0001_110111_1010, 13'b00_11111_1010_01},
        '{"R8 ", 14'b0001_110110_0101, 13'b00_11111_0101_00},
        '{"R8 ", 14'b0000_110110_0101, 13'b00_11111_0101_10},
        '{"R8 ", 14'b1000_110000_0101, 13'b01_00011_0101_10},
        '{"R6 ", 14'b0010_110000_0101, 13'b11_00111_0101_10},
        '{"R10", 14'b0000_110000_0101, 13'b00_11111_0101_10}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [13:0]   stim;
    logic [1:0]    mode;
    logic          core_clk_en, mem_clk_en, sys_clk_en, pll_en, osc_en;
    logic [NP-1:0] per_clk_en;
    logic          wdog_run, pwm_disable;
    logic [12:0]   obs;
    int            n_checks = 0;
    int            n_errors = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl #(.N_PERIPH(NP)) u0 (
        .clk               (clk),
        .rst_n             (rst_n),
        .wait_req          (stim[13]),
        .stop_req          (stim[12]),
        .wake              (stim[11]),
        .debug_mode        (stim[10]),
        .cfg_wait_en       (stim[9]),
        .cfg_stop_en       (stim[8]),
        .cfg_stop_deep     (stim[7]),
        .cfg_wait_wdog_off (stim[6]),
        .cfg_wait_pwm_off  (stim[5]),
        .cfg_dbg_pwm_off   (stim[4]),
        .periph_gate       (stim[3:0]),
        .mode              (mode),
        .core_clk_en       (core_clk_en),
        .mem_clk_en        (mem_clk_en),
        .sys_clk_en        (sys_clk_en),
        .per_clk_en        (per_clk_en),
        .pll_en            (pll_en),
        .osc_en            (osc_en),
        .wdog_run          (wdog_run),
        .pwm_disable       (pwm_disable)
    );

    assign obs = {mode, core_clk_en, mem_clk_en, sys_clk_en, pll_en, osc_en,
                  per_clk_en, wdog_run, pwm_disable};

    task automatic check(input logic [23:0] tag, input logic [12:0] expv);
        n_checks++;
        if (obs !== expv) begin
            n_errors++;
            $display("FAIL %s: got %b expected %b", tag, obs, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        stim  = '0;
        repeat (3) @(negedge clk);
        check("R1 ", 13'b00_11111_0000_10);
        stim  = 14'b0000_110110_1010;
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            stim = VEC[i].stim;
            @(negedge clk);
            check(VEC[i].tag, VEC[i].expv);
        end
        // Directed: reset while in deep stop restores everything (R1).
        stim = 14'b0100_111110_1010;
        @(negedge clk);
        check("R4 ", 13'b10_00000_0000_00);
        stim  = 14'b0000_110110_1010;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 ", 13'b00_11111_0000_10);
        rst_n = 1'b1;
        // After reset the deep flag is clear: shallow stop then a one-step wake (R6).
        @(negedge clk);
        check("R10", 13'b00_11111_1010_10);
        stim = 14'b0100_110110_1010;
        @(negedge clk);
        check("R3 ", 13'b10_00011_0000_00);
        stim = 14'b0010_110110_1010;
        @(negedge clk);
        check("R6 ", 13'b11_00111_1010_10);
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule